// File: doc/BRIEF.md
# Auto-Reload Baud Tick Generator

This block produces the bit-rate timing for a serial port without using any of the general-purpose timers. A free-running counter, `CNT_W` bits wide, counts up. On each count it advances either once per clock or once every `PRE_DIV` clocks (six by default), as a speed bit selects. When the counter wraps past its all-ones value it reloads from a reload register and raises an overflow. That overflow is the raw rate.

Two taps leave the block. The synchronous tap pulses on every overflow and serves the shift-register mode. The serial tap normally passes only every second overflow, which halves the rate. A doubling bit bypasses the halving stage so that the serial tap pulses on every overflow.

Software reaches the block through two write strobes. One strobe loads the control bits and the other loads the reload value. Clearing the run bit freezes the block in its reset state.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset both `sync_tick` and `serial_tick` are 0, the control bits are 0 and the reload value is 0.
- R2: The control word is written with `ctrl_wr`, using bit 0 = run. While run is 0 neither tap pulses and the counter, the prescaler and the halving stage stay at zero. After run is set, with speed = 1 and the counter starting from zero, the first overflow comes on the 256th counter advance (2^CNT_W).
- R3: Speed is `ctrl_wdata` bit 1, and speed = 1 advances the counter on every clock. Consecutive `sync_tick` pulses are then (2^CNT_W − reload) clocks apart. A reload of all ones gives a pulse on every clock.
- R4: With speed = 0 the counter advances once every `PRE_DIV` clocks. Consecutive `sync_tick` pulses are then `PRE_DIV` × (2^CNT_W − reload) clocks apart.
- R5: A write to the reload value through `reload_wr` does not change the count period in progress. The counter takes the new value only at the next overflow.
- R6: Doubling is `ctrl_wdata` bit 2. With doubling = 0, `serial_tick` pulses on every second overflow and always together with `sync_tick`. The first overflow after run is set does not produce a `serial_tick`.
- R7: With doubling = 1, `serial_tick` pulses on every overflow.
- R8: Both taps are registered. Each is high for exactly the one cycle that follows the clock edge at which the counter wraps.
- R9: Clearing run returns the halving stage to zero. After run is set again, the first overflow produces no `serial_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Strobe that loads `ctrl_wdata` into the control bits |
| ctrl_wdata | input | 3 | bit 0 run, bit 1 speed (1 = undivided), bit 2 doubling |
| reload_wr | input | 1 | Strobe that loads `reload_wdata` into the reload value |
| reload_wdata | input | CNT_W | New reload value |
| sync_tick | output | 1 | One-cycle pulse on every overflow (synchronous mode tap) |
| serial_tick | output | 1 | One-cycle pulse on every second overflow, or on every overflow when doubling |

## Verification
A wrong counter or prescaler value does not show up at once. It appears only as a misplaced `sync_tick`, at most one full period later, which can be up to 2^CNT_W × PRE_DIV clocks. For that reason the bench compares both taps on every clock against a behavioural model and also measures exact pulse spacings. A halving stage in the wrong phase shows up at the next overflow as `serial_tick` on the wrong member of a pair. A reload that is applied too early shortens the period in which the write happens.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   typedef struct packed {
      logic dbl;
      logic fast;
      logic run;
   } bg_ctrl_t;

   localparam int unsigned BG_CTRL_W = $bits(bg_ctrl_t);

endpackage

// File: rtl/bg_prescale.sv
module bg_prescale #(
   parameter int unsigned PRE_DIV = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic fast,
   output logic adv
);

   logic slow_wrap;

   generate
      if (PRE_DIV == 1) begin : g_nodiv
         assign slow_wrap = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(PRE_DIV);
         localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
         logic [PW-1:0] phase;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              phase <= '0;
            else if (!run)           phase <= '0;
            else if (phase == LAST)  phase <= '0;
            else                     phase <= phase + 1'b1;
         end

         assign slow_wrap = (phase == LAST);

         // R4: in divided mode two advances are never adjacent
         p_slow_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (run && !fast && adv) |=> (!adv || fast));
         // R2: a stopped prescaler restarts from phase zero
         p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (phase == '0));
      end
   endgenerate

   assign adv = run & (fast | slow_wrap);

endmodule

// File: rtl/bg_reload_cnt.sv
module bg_reload_cnt #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             adv,
   input  logic [CNT_W-1:0] reload,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] TOP = '1;

   logic [CNT_W-1:0] cnt;

   assign wrap = adv & (cnt == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!run)    cnt <= '0;
      else if (wrap)    cnt <= reload;
      else if (adv)     cnt <= cnt + 1'b1;
   end

   // R5: the value present at the wrap is what the counter restarts from
   p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == $past(reload)));
   // R2: counter frozen at zero while stopped
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

endmodule

// File: rtl/bg_out_stage.sv
module bg_out_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic dbl,
   input  logic wrap,
   output logic sync_tick,
   output logic serial_tick
);

   logic half;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       half <= 1'b0;
      else if (!run)    half <= 1'b0;
      else if (wrap)    half <= ~half;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_tick   <= 1'b0;
         serial_tick <= 1'b0;
      end else begin
         sync_tick   <= wrap;
         serial_tick <= wrap & (dbl | half);
      end
   end

   // R6: the serial tap never fires without the synchronous tap
   p_serial_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
      serial_tick |-> sync_tick);
   // R7: doubling passes every overflow through
   p_dbl_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(dbl) && sync_tick) |-> serial_tick);
   // R9: halving stage cleared when stopped
   p_half_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !half);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_gen_pkg::*;
#(
   parameter int unsigned CNT_W   = 8,
   parameter int unsigned PRE_DIV = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr,
   input  logic [BG_CTRL_W-1:0] ctrl_wdata,
   input  logic                 reload_wr,
   input  logic [CNT_W-1:0]     reload_wdata,
   output logic                 sync_tick,
   output logic                 serial_tick
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("baud_tick_gen: CNT_W must lie in 2..32");
      end
      if (PRE_DIV < 1 || PRE_DIV > 65536) begin : g_bad_div
         $error("baud_tick_gen: PRE_DIV must lie in 1..65536");
      end
   endgenerate

   bg_ctrl_t         ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic             adv;
   logic             wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= bg_ctrl_t'(ctrl_wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         reload_q <= '0;
      else if (reload_wr) reload_q <= reload_wdata;
   end

   bg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ctrl_q.run),
      .fast  (ctrl_q.fast),
      .adv   (adv)
   );

   bg_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ctrl_q.run),
      .adv    (adv),
      .reload (reload_q),
      .wrap   (wrap)
   );

   bg_out_stage u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (ctrl_q.run),
      .dbl         (ctrl_q.dbl),
      .wrap        (wrap),
      .sync_tick   (sync_tick),
      .serial_tick (serial_tick)
   );

   // R2: no tap activity one cycle after the block is stopped
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.run && !$past(ctrl_q.run)) |-> (!sync_tick && !serial_tick));

endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;

   localparam int W   = 8;
   localparam int DIV = 6;
   localparam int MOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ctrl_wr = 1'b0;
   logic [2:0]   ctrl_wdata = '0;
   logic         reload_wr = 1'b0;
   logic [W-1:0] reload_wdata = '0;
   logic         sync_tick;
   logic         serial_tick;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   baud_tick_gen #(.CNT_W(W), .PRE_DIV(DIV)) u_baud_tick_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr      (ctrl_wr),
      .ctrl_wdata   (ctrl_wdata),
      .reload_wr    (reload_wr),
      .reload_wdata (reload_wdata),
      .sync_tick    (sync_tick),
      .serial_tick  (serial_tick)
   );

   task automatic chk(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // behavioural reference, integers only
   int  m_run, m_fast, m_dbl, m_rel, m_phase, m_count, m_pair;
   int  e_sync, e_ser;
   bit  m_go, m_wrap;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_run = 0; m_fast = 0; m_dbl = 0; m_rel = 0;
         m_phase = 0; m_count = 0; m_pair = 0; e_sync = 0; e_ser = 0;
      end else begin
         m_go   = (m_run != 0) && (m_fast != 0 || m_phase == DIV - 1);
         m_wrap = m_go && (m_count == MOD - 1);
         e_sync = m_wrap ? 1 : 0;
         e_ser  = (m_wrap && (m_dbl != 0 || m_pair != 0)) ? 1 : 0;
         if (m_run == 0) begin
            m_phase = 0; m_count = 0; m_pair = 0;
         end else begin
            m_phase = (m_phase + 1) % DIV;
            if (m_wrap) begin
               m_count = m_rel;
               m_pair  = 1 - m_pair;
            end else if (m_go) begin
               m_count = m_count + 1;
            end
         end
         if (ctrl_wr) begin
            m_run  = ctrl_wdata[0];
            m_fast = ctrl_wdata[1];
            m_dbl  = ctrl_wdata[2];
         end
         if (reload_wr) m_rel = reload_wdata;
      end
   end

   // R8: cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8", "sync_tick vs model", sync_tick, e_sync);
         chk("R8", "serial_tick vs model", serial_tick, e_ser);
      end
   end

   task automatic step();
      @(negedge clk);
      ctrl_wr   = 1'b0;
      reload_wr = 1'b0;
   endtask

   task automatic put_ctrl(logic [2:0] v);
      ctrl_wdata = v;
      ctrl_wr    = 1'b1;
   endtask

   task automatic put_reload(int v);
      reload_wdata = W'(v);
      reload_wr    = 1'b1;
   endtask

   // clocks until the next sync_tick, counted from the current negedge
   task automatic wait_sync(output int n);
      n = 0;
      do begin
         step();
         n++;
      end while (!sync_tick && n < 5000);
      if (!sync_tick) n = -1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n;
      int hits;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "sync_tick in reset", sync_tick, 0);
      chk("R1", "serial_tick in reset", serial_tick, 0);
      rst_n = 1'b1;
      step();
      chk("R1", "sync_tick after reset", sync_tick, 0);
      chk("R1", "serial_tick after reset", serial_tick, 0);

      // R2: stopped block stays silent
      put_reload(200);
      hits = 0;
      for (int i = 0; i < 300; i++) begin
         step();
         if (sync_tick || serial_tick) hits++;
      end
      chk("R2", "ticks while stopped", hits, 0);

      // R2/R3: run, undivided, no doubling
      put_ctrl(3'b011);
      wait_sync(n);
      chk("R2", "clocks to first overflow", n, MOD + 1);
      chk("R6", "serial on first overflow", serial_tick, 0);
      wait_sync(n);
      chk("R3", "fast period reload 200", n, MOD - 200);
      chk("R6", "serial on second overflow", serial_tick, 1);

      // R5: new reload only after the next wrap
      put_reload(100);
      wait_sync(n);
      chk("R5", "period during reload write", n, MOD - 200);
      chk("R6", "serial on third overflow", serial_tick, 0);
      wait_sync(n);
      chk("R5", "period after reload applies", n, MOD - 100);
      chk("R6", "serial on fourth overflow", serial_tick, 1);

      // R4: divided clock
      put_ctrl(3'b001);
      wait_sync(n);
      wait_sync(n);
      chk("R4", "divided period reload 100", n, DIV * (MOD - 100));

      // R7: doubling passes every overflow
      put_ctrl(3'b111);
      wait_sync(n);
      for (int k = 0; k < 3; k++) begin
         wait_sync(n);
         chk("R3", "fast period while doubling", n, MOD - 100);
         chk("R7", "serial with doubling", serial_tick, 1);
      end

      // R9: stop with the halving stage at one, then restart
      put_ctrl(3'b011);
      wait_sync(n);
      if (serial_tick) wait_sync(n);
      put_ctrl(3'b000);
      hits = 0;
      for (int i = 0; i < 400; i++) begin
         step();
         if (i > 0 && (sync_tick || serial_tick)) hits++;
      end
      chk("R2", "ticks after stop", hits, 0);
      put_ctrl(3'b011);
      wait_sync(n);
      chk("R2", "clocks to first overflow after restart", n, MOD + 1);
      chk("R9", "serial on first overflow after restart", serial_tick, 0);
      wait_sync(n);
      chk("R9", "serial on second overflow after restart", serial_tick, 1);

      // R3 boundary: reload all ones gives a pulse every clock
      put_reload(MOD - 1);
      wait_sync(n);
      wait_sync(n);
      for (int k = 0; k < 4; k++) begin
         wait_sync(n);
         chk("R3", "period with reload all ones", n, 1);
      end

      repeat (3) step();
      finish_run();
   end

endmodule